// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescale

This block guards a chip against runaway software. A free-running prescaler on the system clock produces a tick at one of two rates. A small up counter advances by one on each tick. If software does not strobe the clear input before the counter wraps past its maximum, the block raises a reset request pulse for the chip's reset logic.

A static option input enables the whole function. While it is low, the counter does not move and no request is ever raised. One bit of a small writable control register chooses the tick rate. It defaults to the faster rate, giving an interval of 16 × 2^SHORT_LOG2 clocks. The slower rate gives 16 × 2^LONG_LOG2 clocks.

Top module: `wdog_timer`

## Requirements
- R1: In the cycle after a synchronous reset, `rst_req` is 0, `ctl_rdata` is 0 and the fast tick rate is selected.
- R2: Bit 3 of the 8-bit control register is the rate select, written by `ctl_we`/`ctl_wdata`. It reads back on `ctl_rdata[3]`, and all other bits of `ctl_rdata` read 0.
- R3: The prescaler is a counter zeroed by reset that advances every clock. With bit 3 at 0, a tick occurs in each cycle whose low SHORT_LOG2 prescaler bits are all ones. With no clears, successive request pulses start exactly 16 × 2^SHORT_LOG2 cycles apart.
- R4: With bit 3 at 1, a tick occurs in each cycle where all LONG_LOG2 prescaler bits are ones, and successive pulses start 16 × 2^LONG_LOG2 cycles apart.
- R5: A tick with the count at its maximum (15) raises `rst_req` on the next edge. The request stays high for exactly PULSE_LEN (4) cycles. The count is 0 from the wrap on, and ticks during the pulse are ignored.
- R6: While `wdt_en` is 0, the count holds and `rst_req` never rises.
- R7: A `clr_wdt` strobe sets the count to 0. Strobing it more often than the interval keeps `rst_req` low indefinitely.
- R8: A clear in the same cycle as a tick wins: the count becomes 0 and no request starts, even at count 15. A clear during a pulse does not shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wdt_en | input | 1 | Static option enable |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| rst_req | output | 1 | Registered chip reset request pulse |

## Verification
The bound checker watches every cycle for several properties. It checks that the read data never shows bits other than the rate select, and that every request pulse lasts exactly four cycles. It also checks that a request never starts right after a cycle with the enable low or with a clear, and that pulses are never closer together than fifteen fast ticks. Only the bench's scenarios can show the exact pulse spacing at each rate and the effect of moving the clear across every prescaler phase near the wrap point. The bench shows both with a cycle-by-cycle reference built from the requirements.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    TAP_FAST = 1'b0,
    TAP_SLOW = 1'b1
  } tap_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int SHORT_LOG2 = 11,
  parameter int LONG_LOG2  = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  wdog_pkg::tap_e  tap_sel,
  output logic            tick
);
  localparam int PW = LONG_LOG2;

  logic [PW-1:0] pre_q;
  logic [1:0]    tap_hit;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  generate
    if (SHORT_LOG2 < LONG_LOG2) begin : g_split
      assign tap_hit[0] = &pre_q[SHORT_LOG2-1:0];
    end else begin : g_same
      assign tap_hit[0] = &pre_q;
    end
  endgenerate
  assign tap_hit[1] = &pre_q;

  always_comb begin
    tick = (tap_sel == wdog_pkg::TAP_SLOW) ? tap_hit[1] : tap_hit[0];
  end
endmodule

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg #(
  parameter int DATA_W  = 8,
  parameter int SEL_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output wdog_pkg::tap_e    tap_sel
);
  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst)     sel_q <= 1'b0;
    else if (we) sel_q <= wdata[SEL_BIT];
  end

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_rd
      if (b == SEL_BIT) begin : g_sel
        assign rdata[b] = sel_q;
      end else begin : g_zero
        assign rdata[b] = 1'b0;
      end
    end
  endgenerate

  assign tap_sel = sel_q ? wdog_pkg::TAP_SLOW : wdog_pkg::TAP_FAST;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  input  logic tick,
  input  logic hold,
  output logic wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             adv;

  assign adv  = en && tick && !clr && !hold;
  assign wrap = adv && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic req
);
  localparam int PCW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [PCW-1:0] RELOAD = PCW'(PULSE_LEN - 1);

  logic [PCW-1:0] left_q;
  logic           req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      req_q  <= 1'b0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      req_q  <= 1'b1;
    end else if (start && !req_q) begin
      left_q <= RELOAD;
      req_q  <= 1'b1;
    end else begin
      req_q  <= 1'b0;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CTL_W      = 8,
  parameter int SEL_BIT    = 3,
  parameter int CNT_W      = 4,
  parameter int SHORT_LOG2 = 11,
  parameter int LONG_LOG2  = 14,
  parameter int PULSE_LEN  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wdt_en,
  input  logic             clr_wdt,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic             rst_req
);
  wdog_pkg::tap_e tap_sel;
  logic           tick;
  logic           wrap;
  logic           busy;

  wdog_ctl_reg #(.DATA_W(CTL_W), .SEL_BIT(SEL_BIT)) u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
    .rdata(ctl_rdata), .tap_sel(tap_sel)
  );

  wdog_prescaler #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2)) u_pre (
    .clk(clk), .rst(rst), .tap_sel(tap_sel), .tick(tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(wdt_en), .clr(clr_wdt),
    .tick(tick), .hold(busy), .wrap(wrap)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .start(wrap), .req(busy)
  );

  assign rst_req = busy;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CTL_W      = 8,
  parameter int SEL_BIT    = 3,
  parameter int SHORT_LOG2 = 11,
  parameter int PULSE_LEN  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wdt_en,
  input logic             clr_wdt,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic             rst_req
);
  localparam int MIN_GAP = 15 * (1 << SHORT_LOG2);
  localparam logic [CTL_W-1:0] SEL_MASK = CTL_W'(1) << SEL_BIT;

  int hi_len;
  int gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_len <= 0;
      gap    <= 0;
    end else begin
      hi_len <= rst_req ? hi_len + 1 : 0;
      if (rst_req)               gap <= 0;
      else if (gap < MIN_GAP + 1) gap <= gap + 1;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!rst_req && ctl_rdata == '0)); // R1
  AST_RDATA_MASK: assert property (@(posedge clk) disable iff (rst) (ctl_rdata & ~SEL_MASK) == '0); // R2
  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (rst) $rose(rst_req) |-> gap >= MIN_GAP); // R3
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst) $fell(rst_req) |-> hi_len == PULSE_LEN); // R5
  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (rst) $rose(rst_req) |-> $past(wdt_en)); // R6
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst) clr_wdt |=> !$rose(rst_req)); // R8
endmodule

bind wdog_timer wdog_checker #(
  .CTL_W(CTL_W), .SEL_BIT(SEL_BIT), .SHORT_LOG2(SHORT_LOG2), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk(clk), .rst(rst), .wdt_en(wdt_en), .clr_wdt(clr_wdt),
  .ctl_rdata(ctl_rdata), .rst_req(rst_req)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb_top;
  localparam int S = 3;
  localparam int L = 5;
  localparam int PL = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wdt_en = 1'b0;
  logic       clr_wdt = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       rst_req;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  string cur_req = "R1";
  bit live = 1'b0;

  always #4 clk = ~clk;

  wdog_timer #(.SHORT_LOG2(S), .LONG_LOG2(L), .PULSE_LEN(PL)) dut_i (
    .clk(clk), .rst(rst), .wdt_en(wdt_en), .clr_wdt(clr_wdt),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .rst_req(rst_req)
  );

  // Reference built from the requirement text
  int m_pre, m_cnt, m_p;
  bit m_sel;
  always @(posedge clk) begin
    bit tk;
    bit st;
    if (rst) begin
      m_pre <= 0; m_cnt <= 0; m_p <= 0; m_sel <= 1'b0;
    end else begin
      tk = m_sel ? (m_pre % (1 << L) == (1 << L) - 1) : (m_pre % (1 << S) == (1 << S) - 1);
      st = wdt_en && tk && !clr_wdt && m_p == 0 && m_cnt == 15;
      m_pre <= (m_pre + 1) % (1 << L);
      if (ctl_we) m_sel <= ctl_wdata[3];
      if (m_p != 0) m_p <= m_p - 1;
      else if (st)  m_p <= PL;
      if (clr_wdt)                  m_cnt <= 0;
      else if (m_p != 0)            m_cnt <= m_cnt;
      else if (wdt_en && tk)        m_cnt <= (m_cnt + 1) % 16;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (live && !rst) begin
      check(rst_req == (m_p != 0), cur_req, int'(rst_req), int'(m_p != 0));
      check(ctl_rdata == {4'b0, m_sel, 3'b0}, "R2", int'(ctl_rdata), int'(m_sel) * 8);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL R7 watchdog timeout act=%0d exp=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    ctl_wdata = d; ctl_we = 1'b1; step(1); ctl_we = 1'b0;
  endtask

  task automatic clr1();
    clr_wdt = 1'b1; step(1); clr_wdt = 1'b0;
  endtask

  // Measure cycles between two successive request rises
  task automatic period(output int p);
    int t0;
    while (!rst_req) step(1);
    while (rst_req) step(1);
    while (!rst_req) step(1);
    t0 = cyc;
    while (rst_req) step(1);
    while (!rst_req) step(1);
    p = cyc - t0;
  endtask

  initial begin
    int p;
    int t;
    wdt_en = 1'b1;
    step(3);
    rst = 1'b0;
    // R1: state right after reset
    check(rst_req == 1'b0, "R1", int'(rst_req), 0);
    check(ctl_rdata == 8'h00, "R1", int'(ctl_rdata), 0);
    live = 1'b1;
    // R3: first request 16 fast ticks after reset release
    cur_req = "R3";
    t = 0;
    while (!rst_req && t < 1000) begin step(1); t++; end
    check(t == 16 * (1 << S) - 1 + 1 || t == 16 * (1 << S), "R3", t, 16 * (1 << S));
    // R5: pulse width
    cur_req = "R5";
    t = 0;
    while (rst_req) begin step(1); t++; end
    check(t == PL, "R5", t, PL);
    // R3: spacing at fast rate
    cur_req = "R3";
    period(p);
    check(p == 16 * (1 << S), "R3", p, 16 * (1 << S));
    // R2: only bit 3 sticks
    cur_req = "R2";
    wr(8'hFF); step(1);
    check(ctl_rdata == 8'h08, "R2", int'(ctl_rdata), 8);
    wr(8'hF7); step(1);
    check(ctl_rdata == 8'h00, "R2", int'(ctl_rdata), 0);
    wr(8'h08);
    // R4: spacing at slow rate
    cur_req = "R4";
    period(p);
    check(p == 16 * (1 << L), "R4", p, 16 * (1 << L));
    wr(8'h00);
    // R6: disabled, nothing happens
    cur_req = "R6";
    while (rst_req) step(1);
    wdt_en = 1'b0;
    t = 0;
    for (int i = 0; i < 2000; i++) begin step(1); if (rst_req) t++; end
    check(t == 0, "R6", t, 0);
    wdt_en = 1'b1;
    // R7: periodic clears keep it quiet
    cur_req = "R7";
    clr1();
    t = 0;
    for (int i = 0; i < 30; i++) begin
      step(16 * (1 << S) - 20);
      clr1();
      if (rst_req) t++;
    end
    check(t == 0, "R7", t, 0);
    // R8: sweep a second clear across the wrap window
    cur_req = "R8";
    for (int d = 16 * (1 << S) - 2 * (1 << S); d <= 16 * (1 << S) + 2; d++) begin
      clr1();
      step(d);
      clr1();
      step(3 * (1 << S));
    end
    // R8: clear during a pulse does not shorten it
    while (!rst_req) step(1);
    clr1();
    t = 1;
    while (rst_req) begin step(1); t++; end
    check(t == PL, "R8", t, PL);
    step(200);
    live = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule